// File: doc/BRIEF.md
# Single-Cycle Register-to-Register Integer Core

This block is a compact processor core that completes one instruction per clock. A program counter fetches a 32-bit word from an internal read-only program store. The word is decoded in the same cycle. Up to two operands are read from a 32-entry, 32-bit register file, and one of seven arithmetic, logic or shift operations runs on them. The result is written back to the destination register on the next rising clock edge. Only the register-to-register instruction format is understood. Any other word retires without changing state.

The register file has no load path. On reset each register k takes the value k times a seed parameter, so the program starts from known contents. A combinational debug read port shows any register at any time. The core is meant as a self-contained execution kernel, and its correctness is judged entirely through the register contents that the debug port shows.

Top module: `rtype_core`

## Requirements
- R1: While reset is low, fetch_en_o is 0 and pc_o is 0. Register k (k = 1..31) reads k*REG_SEED modulo 2^32, with REG_SEED defaulting to 32'h9E3779B9, and register 0 reads 0. Reset takes effect asynchronously.
- R2: After rst_n rises, fetch_en_o goes to 1 at the third rising clock edge and then stays at 1. pc_o stays 0 until that edge. It then grows by 4 on every following edge, and the first instruction commits on the fourth edge.
- R3: The program store is indexed by pc_o[5:2] and wraps every 16 words. Its words, in order, are 00214020, 00832022, 00431024, 00214025, 00431026, 00011040, 00043842, 0021483F, 8C214820, 00210020, 00E237C2, 00832800, 00245022, followed by three zero words.
- R4: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6] and function [5:0]. With opcode 0, function 100000 writes rs+rt to rd and function 100010 writes rs-rt to rd, both modulo 2^32.
- R5: With opcode 0, function 100100 writes rs AND rt to rd, 100101 writes rs OR rt, and 100110 writes rs XOR rt.
- R6: With opcode 0, function 000000 writes rt shifted left by the shift amount, and 000010 writes rt shifted right by the shift amount. Both shifts fill with zeros, and rs has no effect on the result.
- R7: Register 0 always reads 0. An instruction whose rd is 0 leaves every register unchanged.
- R8: An instruction with a non-zero opcode, or with opcode 0 and any function code not listed in R4 to R6, leaves every register unchanged.
- R9: A result written by one instruction is the operand value that the next instruction sees. An instruction whose rd equals one of its sources reads the old value of that register.
- R10: dbg_data_o shows the current contents of the register selected by dbg_addr_i, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| dbg_addr_i | input | 5 | Register selected for the debug read |
| dbg_data_o | output | 32 | Contents of the selected register |
| pc_o | output | 32 | Address of the instruction being executed |
| fetch_en_o | output | 1 | Program-store chip enable; high while the core executes |

## Verification
Two functions share a cycle in this core: write-back and operand read, and write-back and debug read. Instructions such as r4=r4-r3 and r2=r2^r3 read a register in the same cycle that writes it. The ROM words also chain each result into the next instruction, and the program wraps several times, so every value depends on the values before it. A behavioural model in the bench predicts the state after each edge. Between edges the bench sweeps all 32 registers through the debug port and compares them, and in each compare a wrong value read during the write cycle shows up as a mismatch. A second, asynchronous reset in mid-run checks that the seeded contents come back and that the start-up latency repeats.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN     = 32;
  localparam int REG_AW   = 5;
  localparam int SHAMT_W  = 5;

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;
  localparam logic [5:0] FN_AND   = 6'b100100;
  localparam logic [5:0] FN_OR    = 6'b100101;
  localparam logic [5:0] FN_XOR   = 6'b100110;
  localparam logic [5:0] FN_SHL   = 6'b000000;
  localparam logic [5:0] FN_SHR   = 6'b000010;

  typedef enum logic [2:0] {
    ALU_NOP, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SHL, ALU_SHR
  } alu_op_e;
endpackage

// File: rtl/rc_fetch.sv
module rc_fetch #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] pc_o,
  output logic            ce_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            ce_q, ce_d;

  always_comb begin
    ce_d = 1'b1;
    pc_d = pc_q;
    if (ce_q) pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ce_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      ce_q <= ce_d;
    end
  end

  assign pc_o = pc_q;
  assign ce_o = ce_q;

  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |=> ce_q);
endmodule

// File: rtl/rc_rom.sv
module rc_rom #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             ce_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [XLEN-1:0]  word_o
);
  // Fixed program (R3); unlisted slots hold zero.
  function automatic logic [XLEN-1:0] prog_word(input int slot);
    logic [31:0] w;
    case (slot)
      0:  w = 32'h0021_4020;
      1:  w = 32'h0083_2022;
      2:  w = 32'h0043_1024;
      3:  w = 32'h0021_4025;
      4:  w = 32'h0043_1026;
      5:  w = 32'h0001_1040;
      6:  w = 32'h0004_3842;
      7:  w = 32'h0021_483F;
      8:  w = 32'h8C21_4820;
      9:  w = 32'h0021_0020;
      10: w = 32'h00E2_37C2;
      11: w = 32'h0083_2800;
      12: w = 32'h0024_5022;
      default: w = 32'h0;
    endcase
    return XLEN'(w);
  endfunction

  always_comb begin
    word_o = '0;
    if (ce_i) word_o = prog_word(int'(idx_i));
  end
endmodule

// File: rtl/rc_decode.sv
module rc_decode
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_i,
  input  logic [XLEN-1:0]     inst_i,
  output alu_op_e             op_o,
  output logic [REG_AW-1:0]   a_addr_o,
  output logic                a_en_o,
  output logic [REG_AW-1:0]   b_addr_o,
  output logic                b_en_o,
  output logic [REG_AW-1:0]   c_addr_o,
  output logic                wr_en_o,
  output logic [SHAMT_W-1:0]  shamt_o
);
  logic [5:0]        opc, fn;
  logic [REG_AW-1:0] rs, rt, rd;

  assign opc = inst_i[31:26];
  assign rs  = inst_i[25:21];
  assign rt  = inst_i[20:16];
  assign rd  = inst_i[15:11];
  assign fn  = inst_i[5:0];

  always_comb begin
    op_o     = ALU_NOP;
    a_addr_o = rs;
    b_addr_o = rt;
    c_addr_o = rd;
    a_en_o   = 1'b0;
    b_en_o   = 1'b0;
    wr_en_o  = 1'b0;
    shamt_o  = inst_i[10:6];
    if (ce_i && opc == OPC_REG) begin
      case (fn)
        FN_ADD: begin op_o = ALU_ADD; a_en_o = 1'b1; b_en_o = 1'b1; wr_en_o = 1'b1; end
        FN_SUB: begin op_o = ALU_SUB; a_en_o = 1'b1; b_en_o = 1'b1; wr_en_o = 1'b1; end
        FN_AND: begin op_o = ALU_AND; a_en_o = 1'b1; b_en_o = 1'b1; wr_en_o = 1'b1; end
        FN_OR:  begin op_o = ALU_OR;  a_en_o = 1'b1; b_en_o = 1'b1; wr_en_o = 1'b1; end
        FN_XOR: begin op_o = ALU_XOR; a_en_o = 1'b1; b_en_o = 1'b1; wr_en_o = 1'b1; end
        FN_SHL: begin op_o = ALU_SHL; a_addr_o = rt; a_en_o = 1'b1; wr_en_o = 1'b1; end
        FN_SHR: begin op_o = ALU_SHR; a_addr_o = rt; a_en_o = 1'b1; wr_en_o = 1'b1; end
        default: ;
      endcase
    end
  end

  assert_nowrite_badopc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (inst_i[31:26] == 6'b000000));
  assert_idle_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |-> !wr_en_o);
  assert_shift_oneport_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o == ALU_SHL || op_o == ALU_SHR) |-> (!b_en_o && a_addr_o == inst_i[20:16]));
endmodule

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter int              XLEN = 32,
  parameter int              NREG = 32,
  parameter logic [XLEN-1:0] SEED = 32'h9E37_79B9,
  localparam int             AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   a_addr_i,
  input  logic            a_en_i,
  output logic [XLEN-1:0] a_data_o,
  input  logic [AW-1:0]   b_addr_i,
  input  logic            b_en_i,
  output logic [XLEN-1:0] b_data_o,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o
);
  logic [NREG-1:0][XLEN-1:0] bank;
  logic [NREG-1:0]           wsel;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (k == 0) begin : g_zero
      assign wsel[k] = 1'b0;
      assign bank[k] = '0;
    end else begin : g_live
      localparam logic [XLEN-1:0] INIT = XLEN'(k) * SEED;
      logic [XLEN-1:0] q, d;
      assign wsel[k] = we_i && (waddr_i == AW'(k));
      always_comb begin
        d = q;
        if (wsel[k]) d = wdata_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= INIT;
        else        q <= d;
      end
      assign bank[k] = q;
    end
  end

  assign a_data_o   = a_en_i ? bank[a_addr_i] : '0;
  assign b_data_o   = b_en_i ? bank[b_addr_i] : '0;
  assign dbg_data_o = bank[dbg_addr_i];

  assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel) && !wsel[0]);
  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && waddr_i != '0) |=> (bank[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  alu_op_e            op_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [XLEN-1:0]    res_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      ALU_SHL: res_o = a_i << shamt_i;
      ALU_SHR: res_o = a_i >> shamt_i;
      default: res_o = '0;
    endcase
  end

  assert_sub_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == ALU_SUB) |-> (res_o + b_i == a_i));
  assert_shr_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == ALU_SHR) |-> (res_o <= a_i));
endmodule

// File: rtl/rtype_core.sv
module rtype_core
  import core_pkg::*;
#(
  parameter int              PC_W      = 32,
  parameter int              ROM_DEPTH = 16,
  parameter logic [XLEN-1:0] REG_SEED  = 32'h9E37_79B9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] dbg_addr_i,
  output logic [XLEN-1:0]   dbg_data_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              fetch_en_o
);
  localparam int IDX_W = $clog2(ROM_DEPTH);

  logic [1:0] sync_q, sync_d;
  logic       rst_s;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end
  assign rst_s = sync_q[1];

  logic [PC_W-1:0]    pc;
  logic               ce;
  logic [XLEN-1:0]    inst;
  alu_op_e            op;
  logic [REG_AW-1:0]  a_addr, b_addr, c_addr;
  logic               a_en, b_en, wr_en;
  logic [SHAMT_W-1:0] shamt;
  logic [XLEN-1:0]    a_data, b_data, result;

  rc_fetch #(.PC_W(PC_W)) u_fetch (
    .clk(clk), .rst_n(rst_s), .pc_o(pc), .ce_o(ce)
  );

  rc_rom #(.XLEN(XLEN), .DEPTH(ROM_DEPTH)) u_rom (
    .ce_i(ce), .idx_i(pc[IDX_W+1:2]), .word_o(inst)
  );

  rc_decode #(.XLEN(XLEN)) u_dec (
    .clk(clk), .rst_n(rst_s), .ce_i(ce), .inst_i(inst),
    .op_o(op), .a_addr_o(a_addr), .a_en_o(a_en),
    .b_addr_o(b_addr), .b_en_o(b_en), .c_addr_o(c_addr),
    .wr_en_o(wr_en), .shamt_o(shamt)
  );

  rc_regfile #(.XLEN(XLEN), .NREG(1 << REG_AW), .SEED(REG_SEED)) u_rf (
    .clk(clk), .rst_n(rst_s),
    .a_addr_i(a_addr), .a_en_i(a_en), .a_data_o(a_data),
    .b_addr_i(b_addr), .b_en_i(b_en), .b_data_o(b_data),
    .we_i(wr_en), .waddr_i(c_addr), .wdata_i(result),
    .dbg_addr_i(dbg_addr_i), .dbg_data_o(dbg_data_o)
  );

  rc_alu #(.XLEN(XLEN)) u_alu (
    .clk(clk), .rst_n(rst_s), .op_i(op), .a_i(a_data), .b_i(b_data),
    .shamt_i(shamt), .res_o(result)
  );

  assign pc_o       = pc;
  assign fetch_en_o = ce;
endmodule

// File: tb/sim_rtype_core.sv
`timescale 1ns/10ps
module sim_rtype_core;
  localparam logic [31:0] SEED = 32'h9E37_79B9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  dbg_addr;
  logic [31:0] dbg_data;
  logic [31:0] pc;
  logic        fetch_en;

  always #5 clk = ~clk;

  rtype_core #(.REG_SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data),
    .pc_o(pc), .fetch_en_o(fetch_en)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [31:0] mdl [32];
  logic [31:0] mpc;
  bit          mce;
  bit          m_rst;
  int          rel_edges;
  string       cur_tag;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Program words as listed in R3
  function automatic logic [31:0] prog(input int i);
    case (i)
      0: return 32'h00214020;  1: return 32'h00832022;
      2: return 32'h00431024;  3: return 32'h00214025;
      4: return 32'h00431026;  5: return 32'h00011040;
      6: return 32'h00043842;  7: return 32'h0021483F;
      8: return 32'h8C214820;  9: return 32'h00210020;
      10: return 32'h00E237C2; 11: return 32'h00832800;
      12: return 32'h00245022;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 32; k++) mdl[k] = 32'(k) * SEED;
    mdl[0] = 32'h0;
    mpc = 32'h0;
    mce = 1'b0;
    rel_edges = 0;
    cur_tag = "R1";
  endtask

  task automatic exec(input logic [31:0] w);
    int rs = int'(w[25:21]);
    int rt = int'(w[20:16]);
    int rd = int'(w[15:11]);
    int sh = int'(w[10:6]);
    logic [31:0] r = 32'h0;
    bit valid = 1'b1;
    string kind;
    if (w[31:26] != 6'd0) begin
      valid = 1'b0; kind = "R8";
    end else begin
      case (w[5:0])
        6'h20: begin r = mdl[rs] + mdl[rt]; kind = "R4"; end
        6'h22: begin r = mdl[rs] - mdl[rt]; kind = "R4"; end
        6'h24: begin r = mdl[rs] & mdl[rt]; kind = "R5"; end
        6'h25: begin r = mdl[rs] | mdl[rt]; kind = "R5"; end
        6'h26: begin r = mdl[rs] ^ mdl[rt]; kind = "R5"; end
        6'h00: begin r = mdl[rt] << sh;     kind = "R6"; end
        6'h02: begin r = mdl[rt] >> sh;     kind = "R6"; end
        default: begin valid = 1'b0; kind = "R8"; end
      endcase
    end
    if (valid && rd == 0) kind = "R7";
    if (valid && rd != 0) mdl[rd] = r;
    cur_tag = $sformatf("%s R9 pc=%0h", kind, mpc);
  endtask

  // Predict the state after the coming rising edge
  task automatic step();
    if (m_rst) return;
    rel_edges++;
    if (mce) begin
      exec(prog(int'((mpc >> 2) & 32'hF)));
      mpc = mpc + 32'd4;
    end
    if (rel_edges >= 3) mce = 1'b1;
  endtask

  task automatic compare_all();
    chk(fetch_en == mce, "R2 fetch_en", {31'd0, fetch_en}, {31'd0, mce});
    chk(pc == mpc, "R2 pc", pc, mpc);
    for (int a = 0; a < 32; a++) begin
      dbg_addr = 5'(a);
      #0.05;
      chk(dbg_data == mdl[a], $sformatf("%s R10 r%0d", cur_tag, a), dbg_data, mdl[a]);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    dbg_addr = 5'd0;
    m_rst = 1'b1;
    model_reset();
    for (int cyc = 0; cyc < 95; cyc++) begin
      @(negedge clk);
      compare_all();
      if (cyc == 3 || cyc == 52) begin
        rst_n = 1'b1;
        m_rst = 1'b0;
      end
      if (cyc == 48) begin
        rst_n = 1'b0;
        #1;
        model_reset();
        m_rst = 1'b1;
        compare_all();  // asynchronous reset effect, R1
      end
      step();
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule